// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block shapes the external reset signal that a watchdog raises when its counter expires. A single configuration register holds a pulse-length field, counted in ticks of a 1 MHz strobe, together with two mode flags: the level the output takes while asserted, and whether the output is driven at all times or only while it is asserted. The counter core supplies a timeout trigger. The external-signal enable chooses whether that trigger produces a pulse. When it does, the block emits exactly one pulse of the programmed length.

The two mode flags never take a plain write. They change only when a write carries one of four key codes in bits 31:24. The length field is written on every register write, whatever the top byte holds. The pad gets a data value and an output enable, so the same port pair serves a push-pull pin and a modelled open-drain pin.

Top module: `wdt_ext_pulse`

## Requirements
- R1: Every register write loads the length field from the low bits of the write data. The field resets to 0xFF and reads back in the same low bits.
- R2: A pulse stays asserted for (field value + 1) rising edges of the 1 MHz tick, so a field of 0 gives one tick. The length is latched when the pulse starts.
- R3: Top byte 0xA5 selects active-high output and 0x5A selects active-low output. The asserted level of pad_o is 1 when active-high and 0 when active-low; the idle level is the opposite.
- R4: Top byte 0xA8 selects push-pull drive and 0x8A selects open-drain drive.
- R5: Any other top-byte value leaves polarity and drive mode unchanged, and the length field is still written.
- R6: Read data bit 31 is 1 when the output is active-high. Read data bit 30 is 1 when the drive is push-pull.
- R7: In push-pull mode pad_oe_o is always 1. In open-drain mode pad_oe_o is 1 only while the pulse is asserted.
- R8: A trigger that arrives while a pulse is in progress is ignored and does not change the pulse length.
- R9: A trigger while ext_en_i is low produces no pulse.
- R10: After reset the output is active-low with open-drain drive, and no pulse is in progress.
- R11: Parameter WIDE_FIELD selects a length field of 8 bits (0) or 20 bits (1). Read data bits between the field and bit 30 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| tick_i | input | 1 | 1 MHz tick strobe, one clock wide |
| trigger_i | input | 1 | Timeout trigger from the counter core |
| ext_en_i | input | 1 | Enables the external pulse |
| pad_o | output | 1 | Pad data value |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
A wrong mode flag is visible immediately in bits 31:30 of the read data. It also shows at the pad as an inverted idle level, or as an output enable that is asserted or released in the wrong mode. A wrong length count or a missed load shows only when a pulse ends. The bench therefore counts the ticks that occur while the pad is asserted and compares that count with the field value plus one. A stuck busy state shows as a pulse that never ends, or as a second trigger that stretches the pulse.

// File: rtl/wdt_pulse_pkg.sv
package wdt_pulse_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0] KEY_ACT_HIGH = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PUSH     = 8'hA8;
  localparam logic [7:0] KEY_OPEN     = 8'h8A;

  function automatic int unsigned field_w(input bit wide);
    return wide ? 20 : 8;
  endfunction
endpackage

// File: rtl/wdt_pulse_cfg.sv
module wdt_pulse_cfg
  import wdt_pulse_pkg::*;
#(
  parameter int unsigned FW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [FW-1:0]     width_o,
  output logic              act_high_o,
  output logic              push_pull_o
);
  logic [7:0] key;
  assign key = wdata_i[DATA_W-1 -: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o     <= '1;
      act_high_o  <= 1'b0;
      push_pull_o <= 1'b0;
    end else if (wr_en_i) begin
      width_o <= wdata_i[FW-1:0];
      case (key)
        KEY_ACT_HIGH: act_high_o  <= 1'b1;
        KEY_ACT_LOW:  act_high_o  <= 1'b0;
        KEY_PUSH:     push_pull_o <= 1'b1;
        KEY_OPEN:     push_pull_o <= 1'b0;
        default: ;
      endcase
    end
  end

  p_width_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(width_o));
  p_key_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key == KEY_ACT_HIGH) |=> act_high_o);
  p_key_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key == KEY_ACT_LOW) |=> !act_high_o);
  p_key_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key == KEY_PUSH) |=> push_pull_o);
  p_key_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key == KEY_OPEN) |=> !push_pull_o);
  p_key_other_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key != KEY_ACT_HIGH && key != KEY_ACT_LOW && key != KEY_PUSH
     && key != KEY_OPEN) |=> ($stable(act_high_o) && $stable(push_pull_o)));
endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
  parameter int unsigned FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          trigger_i,
  input  logic          ext_en_i,
  input  logic [FW-1:0] width_i,
  output logic          busy_o
);
  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (trigger_i && ext_en_i) begin
        busy_o <= 1'b1;
        cnt_q  <= width_i;
      end
    end else if (tick_i) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  p_no_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(trigger_i && ext_en_i)) |=> !busy_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(cnt_q)));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cnt_q == $past(width_i));
endmodule

// File: rtl/wdt_pulse_drive.sv
module wdt_pulse_drive (
  input  logic busy_i,
  input  logic act_high_i,
  input  logic push_pull_i,
  output logic pad_o,
  output logic pad_oe_o
);
  // asserted level equals polarity flag; idle level is its inverse
  assign pad_o    = busy_i ~^ act_high_i;
  assign pad_oe_o = push_pull_i | busy_i;
endmodule

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse
  import wdt_pulse_pkg::*;
#(
  parameter bit WIDE_FIELD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              trigger_i,
  input  logic              ext_en_i,
  output logic              pad_o,
  output logic              pad_oe_o
);
  localparam int unsigned FW  = field_w(WIDE_FIELD);
  localparam int unsigned GAP = DATA_W - 2 - FW;

  logic [FW-1:0] width;
  logic          act_high, push_pull, busy;

  wdt_pulse_cfg #(.FW(FW)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i,
    .width_o(width), .act_high_o(act_high), .push_pull_o(push_pull)
  );

  wdt_pulse_timer #(.FW(FW)) u_timer (
    .clk_i, .rst_ni, .tick_i, .trigger_i, .ext_en_i,
    .width_i(width), .busy_o(busy)
  );

  wdt_pulse_drive u_drive (
    .busy_i(busy), .act_high_i(act_high), .push_pull_i(push_pull),
    .pad_o, .pad_oe_o
  );

  assign rdata_o = {act_high, push_pull, {GAP{1'b0}}, width};

  p_pp_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_pull |-> pad_oe_o);
  p_od_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_pull && !busy) |-> !pad_oe_o);
  p_gap_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-3:FW] == '0);
endmodule

// File: tb/wdt_ext_pulse_tb.sv
module wdt_ext_pulse_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0, trig = 1'b0, ext_en = 1'b0;
  logic        pad, pad_oe;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit m_high, m_pp;
  logic [7:0] m_width;

  always #2.5 clk = ~clk;

  wdt_ext_pulse u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .tick_i(tick), .trigger_i(trig), .ext_en_i(ext_en), .pad_o(pad), .pad_oe_o(pad_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return {m_high, m_pp, 22'b0, m_width};
  endfunction

  task automatic reg_wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    m_width = d[7:0];
    case (d[31:24])
      8'hA5: m_high = 1'b1;
      8'h5A: m_high = 1'b0;
      8'hA8: m_pp = 1'b1;
      8'h8A: m_pp = 1'b0;
      default: ;
    endcase
  endtask

  function automatic bit asserted();
    return pad_oe && (pad == m_high);
  endfunction

  // fires one trigger and counts ticks while the pad is asserted
  task automatic pulse(input int dens, input bit retrig, output int ticks, output bit oe_ok);
    bit seen = 0;
    ticks = 0; oe_ok = 1;
    @(negedge clk); trig = 1'b1; ext_en = 1'b1; tick = 1'b0;
    @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      tick = (dens == 0) ? 1'b1 : (($urandom % dens) == 0);
      if (retrig) trig = ($urandom % 4 == 0);
      if (asserted()) begin
        seen = 1;
        if (tick) ticks++;
        if (!pad_oe) oe_ok = 0;
      end else begin
        if (pad_oe != m_pp) oe_ok = 0;
        if (seen) break;
      end
      @(negedge clk);
    end
    trig = 1'b0; tick = 1'b0;
  endtask

  initial begin
    int t; bit ok;
    logic [7:0] keys [6] = '{8'hA5, 8'h5A, 8'hA8, 8'h8A, 8'h00, 8'h3C};
    void'($urandom(1234));
    m_high = 0; m_pp = 0; m_width = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset readback", rdata, 32'h0000_00FF);
    chk("R10 idle pad level", pad, 1);
    chk("R10 idle oe open-drain", pad_oe, 0);

    pulse(0, 0, t, ok);
    chk("R2 default width 0xFF", t, 256);
    chk("R7 open-drain oe", ok, 1);

    reg_wr(32'h00FF_FF00);
    chk("R1 width 0 and gap R11", rdata, exp_rd());
    pulse(0, 0, t, ok);
    chk("R2 width 0 gives one tick", t, 1);

    reg_wr(32'hA500_0005);
    chk("R3 R6 active-high bit31", rdata, exp_rd());
    chk("R3 idle level low", pad, 0);
    reg_wr(32'hA800_0007);
    chk("R4 R6 push-pull bit30", rdata, exp_rd());
    chk("R7 push-pull idle oe", pad_oe, 1);
    pulse(3, 1, t, ok);
    chk("R8 retrigger ignored length", t, 8);
    chk("R7 oe during pp pulse", ok, 1);

    reg_wr(32'h1200_0009);
    chk("R5 other key keeps modes", rdata, exp_rd());

    // R9: disabled trigger
    @(negedge clk); ext_en = 1'b0; trig = 1'b1; tick = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk);
    chk("R9 no pulse when disabled", asserted(), 0);
    tick = 1'b0;

    for (int k = 0; k < 30; k++) begin
      logic [31:0] d;
      d = {keys[$urandom % 6], 16'($urandom), 8'($urandom % 40)};
      reg_wr(d);
      chk("R1 R5 R6 random readback", rdata, exp_rd());
      chk("R7 random idle oe", pad_oe, m_pp);
      pulse(1 + ($urandom % 3), k[0], t, ok);
      chk("R2 R8 random pulse length", t, m_width + 1);
      chk("R7 random oe", ok, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule